// File: doc/BRIEF.md
# Character LCD Parallel Write Controller

This block turns single-byte requests from on-chip logic into write cycles on an 8-bit parallel character-LCD bus. A requester sees a `ready` output. While it is high, a one-cycle `reqValid` together with a byte and a flag choosing data or instruction starts one transfer. The controller then drives the register-select line and the data byte and produces the enable strobe. The strobe's lead-in, high width and tail are derived at elaboration from the system clock period and the supply range chosen by a parameter. After the strobe the controller waits out the display's execution time before it raises `ready` again. The read/write line is held at write for the whole time.

After reset the controller waits a configurable start-up time. It then programs the display by itself with four instructions: bus width and lines, display on, clear, and entry mode. Only then does it first offer `ready`. Clear (0x01) and cursor home (0x02 or 0x03) as instructions get a long execution wait. Every other instruction, and every data write whatever its value, gets the short wait. Both waits are set in display-controller clock periods and rounded up to system cycles. Each wait is stretched where needed so that the minimum enable cycle time still holds.

Top module: `lcd_write_ctrl`

## Requirements
- R1: While reset is asserted, `lcdE` is 0, `lcdRw` is 0 and `ready` is 0.
- R2: After reset is released, the controller waits STARTUP_CYC cycles and then writes, as instructions (lcdRs = 0), 0x38, 0x0F, 0x01 and 0x06 in that order. `ready` first goes high STARTUP_CYC + 3·(S+H+D+Ws) + (S+H+D+Wl) cycles after the release.
- R3: `lcdRw` is 0 in every cycle.
- R4: For a request accepted at clock edge k, `lcdRs` and `lcdData` take their new values at edge k, and `lcdE` rises at edge k+S. S = ceil(tAS/CLK_NS), where tAS is 40 ns (LOW_VOLT = 0) or 60 ns (LOW_VOLT = 1).
- R5: `lcdE` stays high for exactly H cycles, H = ceil(max(tPW, tDS)/CLK_NS). tPW/tDS are 230/80 ns, or 450/195 ns at low voltage. `lcdRs` and `lcdData` do not change while `lcdE` is high.
- R6: `lcdRs` and `lcdData` keep their values for D cycles after `lcdE` falls, D = ceil(max(tAH, 10 ns)/CLK_NS), where tAH is 10 ns, or 20 ns at low voltage.
- R7: `lcdRs` equals 1 for a data request (reqIsData = 1) and 0 for an instruction, and `lcdData` equals the requested byte.
- R8: For a transfer accepted at edge k, `ready` goes high again at edge k+S+H+D+W. W is Wl for the instructions 0x01, 0x02 and 0x03, and Ws for everything else. Wl is max(ceil(LONG_EXEC_OSC·OSC_NS/CLK_NS), C−S−H−D) and Ws is max(ceil(SHORT_EXEC_OSC·OSC_NS/CLK_NS), C−S−H−D). C = ceil(tC/CLK_NS), and tC is 500 ns, or 1000 ns at low voltage.
- R9: A request is taken only while `ready` is high. Requests presented while `ready` is low start no transfer and do not alter the bus.
- R10: Successive rising edges of `lcdE` are at least C cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, taken while ready is high |
| reqIsData | input | 1 | 1 = data write, 0 = instruction write |
| reqByte | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| lcdRs | output | 1 | Register select to the display |
| lcdRw | output | 1 | Read/write select, held at write (0) |
| lcdE | output | 1 | Enable strobe |
| lcdData | output | 8 | Data bus to the display |

## Verification
Each result is counted in clock edges from the edge that accepts the request. The bus values are due at that edge, the enable rise S edges later and the fall H edges after that. `ready` returns S+H+D+W edges after acceptance, and W depends on the byte class. The bench drives a request at a falling edge and samples once per falling edge afterwards. It records the index of the first sample showing each event and compares it with the figure it computes from the parameters. In the same samples it checks that the bus holds its value through setup, pulse and hold. This is repeated for every data byte, every instruction byte, the start-up sequence and requests pressed while busy.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

  typedef struct packed {
    logic loadBus;
    logic selInit;
    logic eSet;
    logic eClr;
    logic cntLoad;
    logic cntDec;
  } lcdStrobes_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_wr_datapath.sv
module lcd_wr_datapath
  import lcd_wr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] CNT_RESET = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  lcdStrobes_t      stb,
  input  logic             reqIsData,
  input  logic [7:0]       reqByte,
  input  logic [7:0]       initByte,
  input  logic [CNT_W-1:0] cntLoadVal,
  output logic             cntZero,
  output logic             longCmd,
  output logic             lcdRs,
  output logic             lcdE,
  output logic [7:0]       lcdData
);

  logic [CNT_W-1:0] cnt;
  logic             selData;
  logic [7:0]       selByte;
  logic             slowCmd;

  always_comb begin
    selData = stb.selInit ? 1'b0 : reqIsData;
    selByte = stb.selInit ? initByte : reqByte;
    slowCmd = !selData && ((selByte == 8'h01) || (selByte[7:1] == 7'h01));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcdRs   <= 1'b0;
      lcdData <= '0;
      longCmd <= 1'b0;
    end else if (stb.loadBus) begin
      lcdRs   <= selData;
      lcdData <= selByte;
      longCmd <= slowCmd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      lcdE <= 1'b0;
    else if (stb.eSet)
      lcdE <= 1'b1;
    else if (stb.eClr)
      lcdE <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CNT_RESET;
    else if (stb.cntLoad)
      cnt <= cntLoadVal;
    else if (stb.cntDec)
      cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    stb.cntDec |-> !cntZero); // R8

  AST_NO_LOAD_DURING_E: assert property (@(posedge clk) disable iff (rst)
    lcdE |-> !stb.loadBus); // R5

endmodule

// File: rtl/lcd_wr_control.sv
module lcd_wr_control
  import lcd_wr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SETUP_CYC = 1,
  parameter int HIGH_CYC = 1,
  parameter int HOLD_CYC = 1,
  parameter int EXW_SHORT = 1,
  parameter int EXW_LONG = 1,
  parameter logic [7:0] INIT_FUNC = 8'h38,
  parameter logic [7:0] INIT_DISP = 8'h0F,
  parameter logic [7:0] INIT_ENTRY = 8'h06
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             cntZero,
  input  logic             longCmd,
  output lcdStrobes_t      stb,
  output logic [CNT_W-1:0] cntLoadVal,
  output logic [7:0]       initByte,
  output logic             ready
);

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_EXEC
  } wrState_t;

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(EXW_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(EXW_LONG - 1);
  localparam logic [1:0] LAST_INIT = 2'd3;

  wrState_t   state, nextState;
  logic [1:0] initIdx, initPick;
  logic       initActive;

  always_comb begin
    initPick = (state == S_BOOT) ? 2'd0 : initIdx + 2'd1;
    case (initPick)
      2'd0:    initByte = INIT_FUNC;
      2'd1:    initByte = INIT_DISP;
      2'd2:    initByte = 8'h01;
      default: initByte = INIT_ENTRY;
    endcase
  end

  always_comb begin
    stb        = '0;
    nextState  = state;
    cntLoadVal = '0;
    case (state)
      S_BOOT: begin
        if (cntZero) begin
          stb.loadBus = 1'b1;
          stb.selInit = 1'b1;
          stb.cntLoad = 1'b1;
          cntLoadVal  = SETUP_LD;
          nextState   = S_SETUP;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      S_IDLE: begin
        if (reqValid) begin
          stb.loadBus = 1'b1;
          stb.cntLoad = 1'b1;
          cntLoadVal  = SETUP_LD;
          nextState   = S_SETUP;
        end
      end
      S_SETUP: begin
        if (cntZero) begin
          stb.eSet    = 1'b1;
          stb.cntLoad = 1'b1;
          cntLoadVal  = HIGH_LD;
          nextState   = S_PULSE;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      S_PULSE: begin
        if (cntZero) begin
          stb.eClr    = 1'b1;
          stb.cntLoad = 1'b1;
          cntLoadVal  = HOLD_LD;
          nextState   = S_HOLD;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      S_HOLD: begin
        if (cntZero) begin
          stb.cntLoad = 1'b1;
          cntLoadVal  = longCmd ? LONG_LD : SHORT_LD;
          nextState   = S_EXEC;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      S_EXEC: begin
        if (cntZero) begin
          if (initActive && (initIdx != LAST_INIT)) begin
            stb.loadBus = 1'b1;
            stb.selInit = 1'b1;
            stb.cntLoad = 1'b1;
            cntLoadVal  = SETUP_LD;
            nextState   = S_SETUP;
          end else begin
            nextState = S_IDLE;
          end
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_BOOT;
      initIdx    <= 2'd0;
      initActive <= 1'b1;
    end else begin
      state <= nextState;
      if (stb.loadBus && stb.selInit)
        initIdx <= initPick;
      if ((state == S_EXEC) && cntZero && (initIdx == LAST_INIT))
        initActive <= 1'b0;
    end
  end

  assign ready = (state == S_IDLE);

  AST_READY_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (ready && reqValid) |=> !ready); // R9

  AST_INIT_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    ready |-> !initActive); // R2

endmodule

// File: rtl/lcd_write_ctrl.sv
module lcd_write_ctrl
  import lcd_wr_pkg::*;
#(
  parameter bit LOW_VOLT = 1'b0,
  parameter int CLK_NS = 20,
  parameter int OSC_NS = 4000,
  parameter int SHORT_EXEC_OSC = 3,
  parameter int LONG_EXEC_OSC = 165,
  parameter int STARTUP_CYC = 750000,
  parameter logic [7:0] INIT_FUNC = 8'h38,
  parameter logic [7:0] INIT_DISP = 8'h0F,
  parameter logic [7:0] INIT_ENTRY = 8'h06
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqIsData,
  input  logic [7:0] reqByte,
  output logic       ready,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdE,
  output logic [7:0] lcdData
);

  localparam int T_AS  = LOW_VOLT ? 60 : 40;
  localparam int T_AH  = LOW_VOLT ? 20 : 10;
  localparam int T_PW  = LOW_VOLT ? 450 : 230;
  localparam int T_DS  = LOW_VOLT ? 195 : 80;
  localparam int T_DH  = 10;
  localparam int T_CYC = LOW_VOLT ? 1000 : 500;

  localparam int SETUP_CYC = ceilDiv(T_AS, CLK_NS);
  localparam int HIGH_CYC  = ceilDiv(maxOf(T_PW, T_DS), CLK_NS);
  localparam int HOLD_CYC  = ceilDiv(maxOf(T_AH, T_DH), CLK_NS);
  localparam int FLOOR_EXW = maxOf(1, ceilDiv(T_CYC, CLK_NS) - SETUP_CYC - HIGH_CYC - HOLD_CYC);
  localparam int EXW_SHORT = maxOf(ceilDiv(SHORT_EXEC_OSC * OSC_NS, CLK_NS), FLOOR_EXW);
  localparam int EXW_LONG  = maxOf(ceilDiv(LONG_EXEC_OSC * OSC_NS, CLK_NS), FLOOR_EXW);
  localparam int CNT_W     = $clog2(maxOf(maxOf(STARTUP_CYC, EXW_LONG), HIGH_CYC) + 1);
  localparam logic [CNT_W-1:0] BOOT_LD = CNT_W'(maxOf(STARTUP_CYC, 1) - 1);

  lcdStrobes_t      stb;
  logic [CNT_W-1:0] cntLoadVal;
  logic [7:0]       initByte;
  logic             cntZero;
  logic             longCmd;

  lcd_wr_control #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC), .HOLD_CYC(HOLD_CYC),
    .EXW_SHORT(EXW_SHORT), .EXW_LONG(EXW_LONG),
    .INIT_FUNC(INIT_FUNC), .INIT_DISP(INIT_DISP), .INIT_ENTRY(INIT_ENTRY)
  ) i_control (
    .clk(clk), .rst(rst), .reqValid(reqValid), .cntZero(cntZero), .longCmd(longCmd),
    .stb(stb), .cntLoadVal(cntLoadVal), .initByte(initByte), .ready(ready)
  );

  lcd_wr_datapath #(
    .CNT_W(CNT_W), .CNT_RESET(BOOT_LD)
  ) i_datapath (
    .clk(clk), .rst(rst), .stb(stb), .reqIsData(reqIsData), .reqByte(reqByte),
    .initByte(initByte), .cntLoadVal(cntLoadVal), .cntZero(cntZero), .longCmd(longCmd),
    .lcdRs(lcdRs), .lcdE(lcdE), .lcdData(lcdData)
  );

  assign lcdRw = 1'b0;

  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(lcdE) |-> ($stable(lcdRs) && $stable(lcdData))); // R4

  AST_BUS_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(lcdE) && lcdE) |-> ($stable(lcdRs) && $stable(lcdData))); // R5

  AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdE) |-> ($stable(lcdRs) && $stable(lcdData))); // R6

  AST_READY_E_LOW: assert property (@(posedge clk) disable iff (rst)
    ready |-> !lcdE); // R8

endmodule

// File: tb/test_lcd_write_ctrl.sv
module test_lcd_write_ctrl;

  localparam int CLK_NS  = 20;
  localparam int OSC_NS  = 40;
  localparam int STARTUP = 40;
  localparam int S  = (40 + CLK_NS - 1) / CLK_NS;
  localparam int H  = (230 + CLK_NS - 1) / CLK_NS;
  localparam int D  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int C  = (500 + CLK_NS - 1) / CLK_NS;
  localparam int FL = C - S - H - D;
  localparam int WS0 = (3 * OSC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WL0 = (165 * OSC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WS = (WS0 > FL) ? WS0 : FL;
  localparam int WL = (WL0 > FL) ? WL0 : FL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqIsData = 1'b0;
  logic [7:0] reqByte = '0;
  logic ready, lcdRs, lcdRw, lcdE;
  logic [7:0] lcdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int cycleNo = 0;
  bit prevE = 1'b0;
  int logCount = 0;
  logic [8:0] logEntry [0:1023];
  int riseCount = 0;
  int lastRise = 0;
  int minGap = 1000000;
  int rwBad = 0;

  always #10 clk = ~clk;

  lcd_write_ctrl #(
    .CLK_NS(CLK_NS), .OSC_NS(OSC_NS), .STARTUP_CYC(STARTUP)
  ) i_lcd_write_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqIsData(reqIsData), .reqByte(reqByte),
    .ready(ready), .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdE(lcdE), .lcdData(lcdData)
  );

  always @(negedge clk) begin
    cycleNo++;
    if (lcdRw !== 1'b0) rwBad++;
    if (lcdE && !prevE) begin
      if (riseCount > 0 && (cycleNo - lastRise) < minGap) minGap = cycleNo - lastRise;
      lastRise = cycleNo;
      riseCount++;
    end
    if (!lcdE && prevE && logCount < 1024) begin
      logEntry[logCount] = {lcdRs, lcdData};
      logCount++;
    end
    prevE = lcdE;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input bit isData, input logic [7:0] b, input bit junk);
    int expLen, firstRise, firstFall, firstReady, startLog;
    bit busBad;
    expLen = S + H + D + ((!isData && (b == 8'h01 || b == 8'h02 || b == 8'h03)) ? WL : WS);
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqIsData = isData; reqByte = b;
    startLog = logCount;
    firstRise = 0; firstFall = 0; firstReady = 0; busBad = 1'b0;
    for (int i = 1; i <= expLen + 5 && firstReady == 0; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (junk) begin reqIsData = !isData; reqByte = ~b; end
        else reqValid = 1'b0;
      end
      if (i == S + H) reqValid = 1'b0;
      if (i <= S + H + D && (lcdRs !== isData || lcdData !== b)) busBad = 1'b1;
      if (lcdE && firstRise == 0) firstRise = i;
      if (firstRise != 0 && !lcdE && firstFall == 0) firstFall = i;
      if (ready && firstReady == 0) firstReady = i;
    end
    reqValid = 1'b0;
    chk(firstRise == S + 1, "R4 enable rise", firstRise, S + 1);
    chk(firstFall - firstRise == H, "R5 enable width", firstFall - firstRise, H);
    chk(!busBad, "R6 R7 bus value", {23'd0, lcdRs, lcdData}, {23'd0, isData, b});
    chk(firstReady == expLen + 1, "R8 ready return", firstReady, expLen + 1);
    chk(logCount == startLog + 1, "R9 one transfer", logCount - startLog, 1);
  endtask

  initial begin
    int m;
    repeat (3) @(negedge clk);
    chk(lcdE == 1'b0 && ready == 1'b0 && lcdRw == 1'b0, "R1 reset state",
        {lcdE, ready, lcdRw}, 0);
    rst = 1'b0;
    m = 0;
    while (!ready && m < 5000) begin
      @(negedge clk);
      m++;
    end
    chk(m == STARTUP + 3 * (S + H + D + WS) + (S + H + D + WL), "R2 init ready time",
        m, STARTUP + 3 * (S + H + D + WS) + (S + H + D + WL));
    chk(logCount == 4, "R2 init count", logCount, 4);
    chk(logEntry[0] == 9'h038, "R2 init 0", logEntry[0], 9'h038);
    chk(logEntry[1] == 9'h00F, "R2 init 1", logEntry[1], 9'h00F);
    chk(logEntry[2] == 9'h001, "R2 init 2", logEntry[2], 9'h001);
    chk(logEntry[3] == 9'h006, "R2 init 3", logEntry[3], 9'h006);
    for (int b = 0; b < 256; b++) doWrite(1'b1, 8'(b), 1'b0);
    for (int b = 0; b < 256; b++) doWrite(1'b0, 8'(b), 1'b0);
    doWrite(1'b0, 8'h01, 1'b1);
    doWrite(1'b1, 8'h5A, 1'b1);
    doWrite(1'b0, 8'hC0, 1'b1);
    chk(minGap >= C, "R10 enable cycle", minGap, C);
    chk(rwBad == 0, "R3 write only", rwBad, 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule